// File: doc/BRIEF.md
# Configuration Frame Readback Sequencer

This block reads stored configuration frames back out of a frame store and streams them as 128-bit packets, each carrying four 32-bit words. A frame is `FRAME_QW` packets long. The frame store sits outside the block and is reached through a combinational read port. The sequencer drives a frame address and a quadword index. The store answers in the same cycle with a presence flag for that address and the four words of the selected quadword.

There are two ways to launch a readback. A write to the count register starts a multi-frame read at the current frame address. The count is given in quadwords and is divided down to whole frames. A write to the single-frame address register reads exactly one frame. Either launch is accepted only while three enables are all high: row configured, row switched on, and read mode selected. A launch is also refused while the sequencer is busy. Addresses that hold no frame are stepped over without any output. Present frames leave through a valid/ready port that stalls cleanly under backpressure.

Top module: `frame_readback_seq`

## Requirements
- R1: After reset, `busy_o` and `out_valid_o` are low.
- R2: A launch happens only when `row_cfg_i`, `row_on_i` and `rd_en_i` are all high. Otherwise a count or single-frame write leaves `busy_o` low and produces no packets.
- R3: A count write reads the frames at addresses `far_i[22:0]` up to, but not including, that address plus `floor(cnt_i / FRAME_QW)`. Bits 31:23 of `far_i` are ignored.
- R4: A single-frame write reads exactly the one frame at `sfr_addr_i[22:0]`. Bits 31:23 of `sfr_addr_i` are ignored.
- R5: An address whose `st_present_i` is low yields no packets. The walk continues with the next address.
- R6: A present frame is sent as `FRAME_QW` packets with quadword index 0 upward. The packet for index q carries frame words 4q..4q+3, with word 4q in bits 31:0 and word 4q+3 in bits 127:96. Frames go out in increasing address order.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` holds its value. No packet is lost or repeated.
- R8: `busy_o` is high from the cycle after a launch until the last packet is accepted. Count and single-frame writes that arrive while it is high have no effect.
- R9: A count write whose value is below `FRAME_QW` reads nothing, and `busy_o` stays low.
- R10: When a count write and a single-frame write arrive in the same cycle, the count write is the one that is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_cfg_i | input | 1 | Row holds configured frame types |
| row_on_i | input | 1 | Row is switched on |
| rd_en_i | input | 1 | Read-configuration mode is selected |
| far_i | input | REG_W | Current frame address register value |
| cnt_wr_i | input | 1 | Pulse: write of the quadword count register |
| cnt_i | input | CNT_W | Quadword count being written |
| sfr_wr_i | input | 1 | Pulse: write of the single-frame address register |
| sfr_addr_i | input | REG_W | Single-frame address being written |
| st_addr_o | output | ADDR_W | Frame store read address |
| st_qidx_o | output | QW_W | Quadword index within the frame |
| st_present_i | input | 1 | Store holds a frame at `st_addr_o` |
| st_data_i | input | LANES*WORD_W | Words of the selected quadword |
| out_valid_o | output | 1 | Output packet valid |
| out_ready_i | input | 1 | Downstream accepts the packet |
| out_data_o | output | LANES*WORD_W | Output packet |
| busy_o | output | 1 | Readback in progress |

## Verification
A wrong address counter or frame count shows at the output as a missing, extra or reordered packet. Such an error is visible within one frame time of the faulty step, because every packet carries its address and quadword index. A corrupted presence walk shows as packets from an absent address, or as a frame dropped at a present one. A fault in the holding register shows as data that changes during a stall, which is visible in the next stalled cycle. A broken launch gate or busy interlock shows as `busy_o` rising when it must not, one cycle after the offending write.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
   typedef enum logic [1:0] {
      RB_IDLE = 2'd0,
      RB_SCAN = 2'd1,
      RB_SEND = 2'd2
   } rb_state_e;
endpackage

// File: rtl/rbs_launch.sv
module rbs_launch #(
   parameter int REG_W    = 32,
   parameter int ADDR_W   = 23,
   parameter int CNT_W    = 32,
   parameter int FRAME_QW = 4
) (
   input  logic              idle_i,
   input  logic              gate_i,
   input  logic [REG_W-1:0]  far_i,
   input  logic              cnt_wr_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              sfr_wr_i,
   input  logic [REG_W-1:0]  sfr_addr_i,
   output logic              launch_o,
   output logic [ADDR_W-1:0] start_o,
   output logic [CNT_W-1:0]  nframes_o
);
   localparam bit IS_POW2 = (FRAME_QW & (FRAME_QW - 1)) == 0;
   localparam int QW_SH   = (FRAME_QW > 1) ? $clog2(FRAME_QW) : 0;

   logic [CNT_W-1:0] cnt_frames;

   generate
      if (IS_POW2) begin : g_shift
         assign cnt_frames = cnt_i >> QW_SH;
      end else begin : g_div
         assign cnt_frames = cnt_i / CNT_W'(FRAME_QW);
      end
   endgenerate

   always_comb begin
      launch_o  = 1'b0;
      start_o   = far_i[ADDR_W-1:0];
      nframes_o = cnt_frames;
      if (cnt_wr_i) begin
         launch_o = idle_i && gate_i && (cnt_frames != '0);
      end else if (sfr_wr_i) begin
         launch_o  = idle_i && gate_i;
         start_o   = sfr_addr_i[ADDR_W-1:0];
         nframes_o = CNT_W'(1);
      end
   end
endmodule

// File: rtl/rbs_walker.sv
module rbs_walker
   import rbs_pkg::*;
#(
   parameter int ADDR_W   = 23,
   parameter int CNT_W    = 32,
   parameter int FRAME_QW = 4,
   parameter int QW_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_i,
   input  logic [ADDR_W-1:0] start_i,
   input  logic [CNT_W-1:0]  nframes_i,
   input  logic              present_i,
   input  logic              space_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [QW_W-1:0]   qidx_o,
   output logic              load_o,
   output logic              active_o
);
   localparam logic [QW_W-1:0] QW_LAST = QW_W'(FRAME_QW - 1);

   rb_state_e         state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  rem_q;
   logic [QW_W-1:0]   qidx_q;
   logic              step;
   logic              last_frame;

   assign load_o     = (state_q == RB_SEND) && space_i;
   assign step       = ((state_q == RB_SCAN) && !present_i) ||
                       (load_o && (qidx_q == QW_LAST));
   assign last_frame = (rem_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RB_IDLE;
         addr_q  <= '0;
         rem_q   <= '0;
         qidx_q  <= '0;
      end else begin
         case (state_q)
            RB_IDLE: begin
               if (launch_i) begin
                  state_q <= RB_SCAN;
                  addr_q  <= start_i;
                  rem_q   <= nframes_i;
                  qidx_q  <= '0;
               end
            end
            RB_SCAN: begin
               if (present_i) begin
                  state_q <= RB_SEND;
                  qidx_q  <= '0;
               end
            end
            RB_SEND: begin
               if (load_o) qidx_q <= (qidx_q == QW_LAST) ? '0 : qidx_q + QW_W'(1);
            end
            default: state_q <= RB_IDLE;
         endcase
         if (step) begin
            addr_q  <= addr_q + ADDR_W'(1);
            rem_q   <= rem_q - CNT_W'(1);
            state_q <= last_frame ? RB_IDLE : RB_SCAN;
         end
      end
   end

   assign addr_o   = addr_q;
   assign qidx_o   = qidx_q;
   assign active_o = (state_q != RB_IDLE);
endmodule

// File: rtl/rbs_out_reg.sv
module rbs_out_reg #(
   parameter int DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              ready_i,
   output logic              space_o,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o
);
   logic              valid_q;
   logic [DATA_W-1:0] data_q;

   assign space_o = !valid_q || ready_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else if (load_i) begin
         valid_q <= 1'b1;
         data_q  <= data_i;
      end else if (ready_i) begin
         valid_q <= 1'b0;
      end
   end

   assign valid_o = valid_q;
   assign data_o  = data_q;
endmodule

// File: rtl/frame_readback_seq.sv
module frame_readback_seq #(
   parameter int REG_W    = 32,
   parameter int ADDR_W   = 23,
   parameter int CNT_W    = 32,
   parameter int WORD_W   = 32,
   parameter int LANES    = 4,
   parameter int FRAME_QW = 4,
   parameter int QW_W     = (FRAME_QW > 1) ? $clog2(FRAME_QW) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      row_cfg_i,
   input  logic                      row_on_i,
   input  logic                      rd_en_i,
   input  logic [REG_W-1:0]          far_i,
   input  logic                      cnt_wr_i,
   input  logic [CNT_W-1:0]          cnt_i,
   input  logic                      sfr_wr_i,
   input  logic [REG_W-1:0]          sfr_addr_i,
   output logic [ADDR_W-1:0]         st_addr_o,
   output logic [QW_W-1:0]           st_qidx_o,
   input  logic                      st_present_i,
   input  logic [LANES*WORD_W-1:0]   st_data_i,
   output logic                      out_valid_o,
   input  logic                      out_ready_i,
   output logic [LANES*WORD_W-1:0]   out_data_o,
   output logic                      busy_o
);
   localparam int DATA_W = LANES * WORD_W;

   generate
      if (FRAME_QW < 1) begin : g_bad_qw
         $error("FRAME_QW must be at least 1");
      end
      if (ADDR_W > REG_W) begin : g_bad_addr
         $error("ADDR_W must not exceed REG_W");
      end
      if (QW_W < 1 || (FRAME_QW > 1 && (1 << QW_W) < FRAME_QW)) begin : g_bad_qww
         $error("QW_W too narrow for FRAME_QW");
      end
   endgenerate

   logic              launch;
   logic [ADDR_W-1:0] start_addr;
   logic [CNT_W-1:0]  nframes;
   logic              load;
   logic              space;
   logic              active;

   rbs_launch #(
      .REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FRAME_QW(FRAME_QW)
   ) i_launch (
      .idle_i    (!busy_o),
      .gate_i    (row_cfg_i && row_on_i && rd_en_i),
      .far_i     (far_i),
      .cnt_wr_i  (cnt_wr_i),
      .cnt_i     (cnt_i),
      .sfr_wr_i  (sfr_wr_i),
      .sfr_addr_i(sfr_addr_i),
      .launch_o  (launch),
      .start_o   (start_addr),
      .nframes_o (nframes)
   );

   rbs_walker #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FRAME_QW(FRAME_QW), .QW_W(QW_W)
   ) i_walker (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch_i (launch),
      .start_i  (start_addr),
      .nframes_i(nframes),
      .present_i(st_present_i),
      .space_i  (space),
      .addr_o   (st_addr_o),
      .qidx_o   (st_qidx_o),
      .load_o   (load),
      .active_o (active)
   );

   rbs_out_reg #(
      .DATA_W(DATA_W)
   ) i_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .data_i (st_data_i),
      .ready_i(out_ready_i),
      .space_o(space),
      .valid_o(out_valid_o),
      .data_o (out_data_o)
   );

   assign busy_o = active || out_valid_o;
endmodule

// File: rtl/rbs_seq_chk.sv
module rbs_seq_chk #(
   parameter int REG_W    = 32,
   parameter int ADDR_W   = 23,
   parameter int CNT_W    = 32,
   parameter int DATA_W   = 128,
   parameter int FRAME_QW = 4,
   parameter int QW_W     = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              row_cfg_i,
   input logic              row_on_i,
   input logic              rd_en_i,
   input logic              cnt_wr_i,
   input logic [CNT_W-1:0]  cnt_i,
   input logic              sfr_wr_i,
   input logic [QW_W-1:0]   st_qidx_o,
   input logic              out_valid_o,
   input logic              out_ready_i,
   input logic [DATA_W-1:0] out_data_o,
   input logic              busy_o
);
   logic gate;
   assign gate = row_cfg_i && row_on_i && rd_en_i;

   // R1
   a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!busy_o && !out_valid_o));

   // R2
   a_r2_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !gate) |=> !busy_o);

   // R4
   a_r4_single_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && gate && sfr_wr_i && !cnt_wr_i) |=> busy_o);

   // R6
   a_r6_qidx_order: assert property (@(posedge clk) disable iff (!rst_n)
      (st_qidx_o != $past(st_qidx_o)) |->
         (st_qidx_o == '0 || st_qidx_o == $past(st_qidx_o) + QW_W'(1)));

   // R7
   a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

   // R9
   a_r9_short_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && cnt_wr_i && (cnt_i < CNT_W'(FRAME_QW))) |=> !busy_o);
endmodule

bind frame_readback_seq rbs_seq_chk #(
   .REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(LANES*WORD_W),
   .FRAME_QW(FRAME_QW), .QW_W(QW_W)
) i_rbs_seq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .row_cfg_i  (row_cfg_i),
   .row_on_i   (row_on_i),
   .rd_en_i    (rd_en_i),
   .cnt_wr_i   (cnt_wr_i),
   .cnt_i      (cnt_i),
   .sfr_wr_i   (sfr_wr_i),
   .st_qidx_o  (st_qidx_o),
   .out_valid_o(out_valid_o),
   .out_ready_i(out_ready_i),
   .out_data_o (out_data_o),
   .busy_o     (busy_o)
);

// File: tb/test_frame_readback_seq.sv
module test_frame_readback_seq;
   localparam int CLK_PERIOD = 10;
   localparam int FQW    = 3;
   localparam int QWW    = 2;
   localparam int AW     = 23;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          row_cfg = 1'b1, row_on = 1'b1, rd_en = 1'b1;
   logic [31:0]   far = '0, sfr_addr = '0, cnt = '0;
   logic          cnt_wr = 1'b0, sfr_wr = 1'b0;
   logic [AW-1:0] st_addr;
   logic [QWW-1:0] st_qidx;
   logic          st_present;
   logic [127:0]  st_data, out_data;
   logic          out_valid, busy;
   logic          out_ready = 1'b1;
   logic          gaps_on = 1'b0;
   logic          bp_on = 1'b0;

   int checks = 0, failures = 0, cyc = 0;
   logic [127:0] exp_q[$];
   logic [127:0] got_q[$];
   logic         stall_pend = 1'b0;
   logic [127:0] stall_data = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [127:0] pkt(input logic [AW-1:0] a, input int q);
      logic [127:0] p;
      for (int l = 0; l < 4; l++) p[l*32 +: 32] = {8'hC3, a[11:0], 8'(q), 4'(l)};
      return p;
   endfunction

   function automatic logic has_frame(input logic [AW-1:0] a);
      return !gaps_on || ((a % 5) != 2);
   endfunction

   assign st_present = has_frame(st_addr);
   assign st_data    = pkt(st_addr, int'(st_qidx));

   frame_readback_seq #(.FRAME_QW(FQW), .QW_W(QWW)) i_frame_readback_seq (
      .clk(clk), .rst_n(rst_n), .row_cfg_i(row_cfg), .row_on_i(row_on),
      .rd_en_i(rd_en), .far_i(far), .cnt_wr_i(cnt_wr), .cnt_i(cnt),
      .sfr_wr_i(sfr_wr), .sfr_addr_i(sfr_addr), .st_addr_o(st_addr),
      .st_qidx_o(st_qidx), .st_present_i(st_present), .st_data_i(st_data),
      .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
      .busy_o(busy)
   );

   task automatic check(input logic ok, input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Collector: one negedge per cycle; ready for the coming edge is set first.
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (stall_pend)
            check(out_valid && out_data == stall_data, "R7", "stall hold",
                  out_data, stall_data);
         out_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
         if (out_valid && out_ready) got_q.push_back(out_data);
         stall_pend = out_valid && !out_ready;
         stall_data = out_data;
      end
   end

   task automatic expect_range(input logic [AW-1:0] a0, input int n);
      for (int f = 0; f < n; f++) begin
         logic [AW-1:0] a = a0 + AW'(f);
         if (has_frame(a))
            for (int q = 0; q < FQW; q++) exp_q.push_back(pkt(a, q));
      end
   endtask

   task automatic launch(input logic do_cnt, input logic [31:0] c,
                         input logic do_sfr, input logic [31:0] s);
      @(negedge clk);
      cnt_wr = do_cnt; cnt = c; sfr_wr = do_sfr; sfr_addr = s;
      @(negedge clk);
      cnt_wr = 1'b0; sfr_wr = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic compare(input string req);
      check(got_q.size() == exp_q.size(), req, "packet count",
            128'(got_q.size()), 128'(exp_q.size()));
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
         check(got_q[i] == exp_q[i], req, $sformatf("packet %0d", i),
               got_q[i], exp_q[i]);
      exp_q.delete(); got_q.delete();
   endtask

   task automatic t_reset();
      check(!busy && !out_valid, "R1", "idle after reset",
            {126'b0, busy, out_valid}, 128'b0);
   endtask

   task automatic t_multi();   // R3 R6: upper far bits ignored, 9 qw -> 3 frames
      far = 32'hFF80_0004;
      expect_range(AW'(4), 3);
      launch(1'b1, 32'd9, 1'b0, '0);
      check(busy, "R8", "busy after launch", {127'b0, busy}, 128'd1);
      wait_idle();
      compare("R3");
   endtask

   task automatic t_partial();  // R3: 8 qw -> 2 frames (remainder dropped)
      far = 32'd20;
      expect_range(AW'(20), 2);
      launch(1'b1, 32'd8, 1'b0, '0);
      wait_idle();
      compare("R3");
   endtask

   task automatic t_gaps();     // R5: addresses 2 and 7 absent
      gaps_on = 1'b1; far = 32'd0;
      expect_range(AW'(0), 8);
      launch(1'b1, 32'd24, 1'b0, '0);
      wait_idle();
      compare("R5");
      gaps_on = 1'b0;
   endtask

   task automatic t_bp();       // R7 under backpressure
      bp_on = 1'b1; far = 32'd40;
      expect_range(AW'(40), 3);
      launch(1'b1, 32'd9, 1'b0, '0);
      wait_idle();
      compare("R7");
      bp_on = 1'b0;
   endtask

   task automatic t_single();   // R4
      expect_range(AW'(5), 1);
      launch(1'b0, '0, 1'b1, 32'hFF80_0005);
      wait_idle();
      compare("R4");
   endtask

   task automatic t_gate();     // R2
      row_on = 1'b0;
      launch(1'b1, 32'd9, 1'b1, 32'd3);
      check(!busy, "R2", "row off blocks", {127'b0, busy}, 128'd0);
      row_on = 1'b1; rd_en = 1'b0;
      launch(1'b1, 32'd9, 1'b0, '0);
      check(!busy, "R2", "read off blocks", {127'b0, busy}, 128'd0);
      rd_en = 1'b1; row_cfg = 1'b0;
      launch(1'b0, '0, 1'b1, 32'd3);
      check(!busy, "R2", "unconfigured blocks", {127'b0, busy}, 128'd0);
      row_cfg = 1'b1;
      wait_idle();
      compare("R2");
   endtask

   task automatic t_small();    // R9
      launch(1'b1, 32'(FQW - 1), 1'b0, '0);
      check(!busy, "R9", "short count idle", {127'b0, busy}, 128'd0);
      wait_idle();
      compare("R9");
   endtask

   task automatic t_busy_ignore();  // R8
      bp_on = 1'b1; far = 32'd10;
      expect_range(AW'(10), 2);
      launch(1'b1, 32'd6, 1'b0, '0);
      repeat (3) @(negedge clk);
      launch(1'b0, '0, 1'b1, 32'd30);
      launch(1'b1, 32'd30, 1'b0, '0);
      wait_idle();
      bp_on = 1'b0;
      compare("R8");
   endtask

   task automatic t_both();     // R10
      far = 32'd50;
      expect_range(AW'(50), 2);
      launch(1'b1, 32'd6, 1'b1, 32'd60);
      wait_idle();
      compare("R10");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_multi();
      t_partial();
      t_gaps();
      t_bp();
      t_single();
      t_gate();
      t_small();
      t_busy_ignore();
      t_both();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule